// File: doc/BRIEF.md
# Audio Clock Ratio Detector

This block watches the three clocks of a serial audio link: the master clock, the bit clock and the frame clock. Its own reference clock is free-running and unrelated to them. All three inputs are resynchronised to the reference clock and reduced to rising-edge pulses. One frame runs from one rising edge of the frame clock to the next. Over each frame the block counts master-clock edges, bit-clock edges and reference cycles.

At the end of every frame it classifies the master-clock count into a ratio code and the frame length into a sample-rate code. It then checks that the bit-clock count is a legal one for the detected master ratio. It also compares the three measurements with those of the frame before.

Any anomaly sets a sticky error flag. A flag stays set until software writes a zero to its bit. Software then reads the flags again to learn whether the fault is still there. If the frame clock stops, a timeout flags it, and the block arms itself again on the next frame edge.

Top module: `audio_clk_ratio_det`

## Requirements
- R1: After reset the status byte reads 0xFC: the rate code (bits 7:5) and the ratio code (bits 4:2) both hold 7 ("none"), and bits 1:0 are always 0. All error flags are 0.
- R2: A frame is measured only between two rising frame-clock edges. After reset or a timeout, the first rising edge only arms the counters. The status codes change only in the cycle after a frame completes or a timeout occurs.
- R3: Master-clock edges per frame within ±M_TOL (default 1) of 64, 128, 192, 256, 384 or 512 give ratio codes 0 to 5 in that order. Any other count gives code 7.
- R4: The frame length P in reference cycles selects the rate code. P > REF_HZ/6000 gives 7. Otherwise the code is the first rule that holds: P > REF_HZ/12000 gives 0 (8 kHz); P > REF_HZ/19000 gives 1 (16 kHz); P > REF_HZ/28000 gives 2 (22.05/24 kHz); P > REF_HZ/38000 gives 3 (32 kHz); P > REF_HZ/66000 gives 4 (44.1/48 kHz); P > REF_HZ/130000 gives 5 (88.2/96 kHz). If none holds, the code is 7.
- R5: A bit-clock count of 32 or 64 per frame is always legal. A count of 48 is legal only with ratio code 2 (192x) or 4 (384x). Every other count sets the bit-clock flag, err_flags[1].
- R6: When a frame completes and a previous frame exists, three differences raise flags. A master count differing by more than M_TOL sets err_flags[0]. Any difference in the bit count sets err_flags[1]. A frame length differing by more than P_TOL (default 2) sets err_flags[2]. A steady legal stream raises no flag.
- R7: Ratio code 7 at frame end sets err_flags[0]. Rate code 7 at frame end sets err_flags[2].
- R8: Error flags are sticky. A write (wr_en high) clears each flag whose wr_data bit is 0 and keeps each flag whose bit is 1. An error detected in the same cycle as a write takes precedence.
- R9: If no rising frame-clock edge arrives within REF_HZ/MIN_RATE_HZ reference cycles of the last one, the block sets err_flags[2] and returns both codes to 7. It re-arms on the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mclk_in | input | 1 | Master clock, asynchronous |
| bclk_in | input | 1 | Bit clock, asynchronous |
| fclk_in | input | 1 | Frame (left/right) clock, asynchronous |
| wr_en | input | 1 | Error-flag write strobe |
| wr_data | input | 3 | Per-flag keep mask; 0 clears the flag |
| status | output | 8 | {rate code, ratio code, 2'b00} |
| err_flags | output | 3 | [0] master count, [1] bit count, [2] frame clock |

## Verification
A corrupted count or stale previous-frame value shows at the ports one frame later, either as a wrong code or as a flag raised on a steady stream. At 48 kHz that is at most one frame, 512 reference cycles in the bench setup. A wrong arming state shows as codes changing after the very first frame edge, or as a missed timeout. A broken clear or sticky path shows as a flag that drops without a write, or that survives a write of zero. The cycle-level model catches each of these on the first cycle where the outputs diverge.

// File: rtl/acd_pkg.sv
package acd_pkg;

    localparam int unsigned NUM_RATIOS = 6;
    localparam int unsigned NUM_EDGES  = 7;
    localparam int unsigned NUM_ERR    = 3;
    localparam int unsigned LANES      = 3;

    // lane positions of the synchronised clocks
    localparam int unsigned LANE_M = 0;
    localparam int unsigned LANE_B = 1;
    localparam int unsigned LANE_F = 2;

    // error flag positions
    localparam int unsigned ERR_M = 0;
    localparam int unsigned ERR_B = 1;
    localparam int unsigned ERR_F = 2;

    localparam logic [2:0] CODE_NONE = 3'd7;
    localparam logic [2:0] CODE_R192 = 3'd2;
    localparam logic [2:0] CODE_R384 = 3'd4;

    // supported master-clock multiples, index equals ratio code
    function automatic int unsigned ratio_nominal(int unsigned idx);
        case (idx)
            0:       return 64;
            1:       return 128;
            2:       return 192;
            3:       return 256;
            4:       return 384;
            default: return 512;
        endcase
    endfunction

    // rate band boundaries in Hz, slowest first
    function automatic int unsigned rate_edge_hz(int unsigned idx);
        case (idx)
            0:       return 6000;
            1:       return 12000;
            2:       return 19000;
            3:       return 28000;
            4:       return 38000;
            5:       return 66000;
            default: return 130000;
        endcase
    endfunction

endpackage

// File: rtl/acd_edge_sync.sv
module acd_edge_sync #(
    parameter int unsigned N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] raw,
    output logic [N-1:0] rise
);

    typedef struct packed {
        logic [N-1:0] s1;
        logic [N-1:0] s2;
        logic [N-1:0] s3;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d    = sync_q;
        sync_d.s1 = raw;
        sync_d.s2 = sync_q.s1;
        sync_d.s3 = sync_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    for (genvar i = 0; i < N; i++) begin : g_lane
        assign rise[i] = sync_q.s2[i] & ~sync_q.s3[i];
    end

endmodule

// File: rtl/acd_classify.sv
module acd_classify
    import acd_pkg::*;
#(
    parameter int unsigned REF_HZ = 24_576_000,
    parameter int unsigned MCNT_W = 11,
    parameter int unsigned BCNT_W = 7,
    parameter int unsigned PCNT_W = 13,
    parameter int unsigned M_TOL  = 1
) (
    input  logic [MCNT_W-1:0] mclk_cnt,
    input  logic [BCNT_W-1:0] bclk_cnt,
    input  logic [PCNT_W-1:0] period,
    output logic [2:0]        ratio_code,
    output logic [2:0]        rate_code,
    output logic              bclk_ok
);

    logic [NUM_RATIOS-1:0] hit;
    logic [NUM_EDGES-1:0]  slower;
    int unsigned           band_cnt;

    for (genvar i = 0; i < NUM_RATIOS; i++) begin : g_ratio
        localparam int unsigned NOM = ratio_nominal(i);
        assign hit[i] = (32'(mclk_cnt) + M_TOL >= NOM) &&
                        (32'(mclk_cnt) <= NOM + M_TOL);
    end

    for (genvar e = 0; e < NUM_EDGES; e++) begin : g_edge
        localparam int unsigned LIM = REF_HZ / rate_edge_hz(e);
        assign slower[e] = 32'(period) > LIM;
    end

    always_comb begin
        ratio_code = CODE_NONE;
        for (int i = NUM_RATIOS - 1; i >= 0; i--) begin
            if (hit[i]) ratio_code = 3'(i);
        end
    end

    always_comb begin
        band_cnt  = $countones(slower[NUM_EDGES-1:1]);
        rate_code = CODE_NONE;
        if (!slower[0] && band_cnt != 0) begin
            rate_code = 3'(NUM_EDGES - 1 - band_cnt);
        end
    end

    always_comb begin
        bclk_ok = (32'(bclk_cnt) == 32) || (32'(bclk_cnt) == 64) ||
                  ((32'(bclk_cnt) == 48) &&
                   (ratio_code == CODE_R192 || ratio_code == CODE_R384));
    end

endmodule

// File: rtl/audio_clk_ratio_det.sv
module audio_clk_ratio_det
    import acd_pkg::*;
#(
    parameter int unsigned REF_HZ      = 24_576_000,
    parameter int unsigned MIN_RATE_HZ = 4000,
    parameter int unsigned MCNT_W      = 11,
    parameter int unsigned BCNT_W      = 7,
    parameter int unsigned M_TOL       = 1,
    parameter int unsigned P_TOL       = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mclk_in,
    input  logic       bclk_in,
    input  logic       fclk_in,
    input  logic       wr_en,
    input  logic [2:0] wr_data,
    output logic [7:0] status,
    output logic [2:0] err_flags
);

    localparam int unsigned TIMEOUT = REF_HZ / MIN_RATE_HZ;
    localparam int unsigned PCNT_W  = $clog2(TIMEOUT + 1);

    typedef struct packed {
        logic               armed;
        logic               have_prev;
        logic [MCNT_W-1:0]  mcnt;
        logic [BCNT_W-1:0]  bcnt;
        logic [PCNT_W-1:0]  pcnt;
        logic [MCNT_W-1:0]  prev_m;
        logic [BCNT_W-1:0]  prev_b;
        logic [PCNT_W-1:0]  prev_p;
        logic [2:0]         rate;
        logic [2:0]         ratio;
        logic [NUM_ERR-1:0] err;
    } det_t;

    det_t det_d, det_q;

    logic [LANES-1:0]   rise;
    logic               frame_done;
    logic               timeout;
    logic [2:0]         cls_ratio;
    logic [2:0]         cls_rate;
    logic               cls_bok;
    logic [MCNT_W-1:0]  diff_m;
    logic [PCNT_W-1:0]  diff_p;
    logic [NUM_ERR-1:0] new_err;
    logic [NUM_ERR-1:0] keep_mask;

    acd_edge_sync #(.N(LANES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .raw  ({fclk_in, bclk_in, mclk_in}),
        .rise (rise)
    );

    acd_classify #(
        .REF_HZ(REF_HZ),
        .MCNT_W(MCNT_W),
        .BCNT_W(BCNT_W),
        .PCNT_W(PCNT_W),
        .M_TOL (M_TOL)
    ) u_cls (
        .mclk_cnt  (det_q.mcnt),
        .bclk_cnt  (det_q.bcnt),
        .period    (det_q.pcnt),
        .ratio_code(cls_ratio),
        .rate_code (cls_rate),
        .bclk_ok   (cls_bok)
    );

    assign frame_done = rise[LANE_F] & det_q.armed;
    assign timeout    = ~rise[LANE_F] & det_q.armed &
                        (det_q.pcnt == PCNT_W'(TIMEOUT));

    always_comb begin
        diff_m = (det_q.mcnt > det_q.prev_m) ? det_q.mcnt - det_q.prev_m
                                             : det_q.prev_m - det_q.mcnt;
        diff_p = (det_q.pcnt > det_q.prev_p) ? det_q.pcnt - det_q.prev_p
                                             : det_q.prev_p - det_q.pcnt;
    end

    always_comb begin
        det_d     = det_q;
        new_err   = '0;
        keep_mask = wr_en ? wr_data : '1;

        // per-frame counting
        if (rise[LANE_F]) begin
            det_d.armed = 1'b1;
            det_d.mcnt  = MCNT_W'(rise[LANE_M]);
            det_d.bcnt  = BCNT_W'(rise[LANE_B]);
            det_d.pcnt  = PCNT_W'(1);
        end else if (det_q.armed && !timeout) begin
            if (rise[LANE_M] && det_q.mcnt != '1) det_d.mcnt = det_q.mcnt + 1'b1;
            if (rise[LANE_B] && det_q.bcnt != '1) det_d.bcnt = det_q.bcnt + 1'b1;
            det_d.pcnt = det_q.pcnt + 1'b1;
        end

        // stopped frame clock
        if (timeout) begin
            det_d.armed     = 1'b0;
            det_d.have_prev = 1'b0;
            det_d.rate      = CODE_NONE;
            det_d.ratio     = CODE_NONE;
            new_err[ERR_F]  = 1'b1;
        end

        // frame completion: classify, check legality, compare
        if (frame_done) begin
            if (cls_ratio == CODE_NONE) new_err[ERR_M] = 1'b1;
            if (!cls_bok)               new_err[ERR_B] = 1'b1;
            if (cls_rate == CODE_NONE)  new_err[ERR_F] = 1'b1;
            if (det_q.have_prev) begin
                if (diff_m > MCNT_W'(M_TOL))     new_err[ERR_M] = 1'b1;
                if (det_q.bcnt != det_q.prev_b)  new_err[ERR_B] = 1'b1;
                if (diff_p > PCNT_W'(P_TOL))     new_err[ERR_F] = 1'b1;
            end
            det_d.prev_m    = det_q.mcnt;
            det_d.prev_b    = det_q.bcnt;
            det_d.prev_p    = det_q.pcnt;
            det_d.have_prev = 1'b1;
            det_d.ratio     = cls_ratio;
            det_d.rate      = cls_rate;
        end

        det_d.err = (det_q.err & keep_mask) | new_err;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            det_q       <= '0;
            det_q.rate  <= CODE_NONE;
            det_q.ratio <= CODE_NONE;
        end else begin
            det_q <= det_d;
        end
    end

    assign status    = {det_q.rate, det_q.ratio, 2'b00};
    assign err_flags = det_q.err;

endmodule

// File: rtl/acd_chk.sv
module acd_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] status,
    input logic [2:0] err_flags,
    input logic       wr_en,
    input logic [2:0] wr_data,
    input logic       frame_done,
    input logic       timeout
);

    // R1
    pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status[1:0] == 2'b00);

    // R3
    ratio_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status[4:2] != 3'd6);

    // R4
    rate_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status[7:5] != 3'd6);

    // R2
    code_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(status) |-> $past(frame_done || timeout));

    // R9
    timeout_chk: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |=> (status[7:2] == 6'h3F) && err_flags[2]);

    for (genvar i = 0; i < 3; i++) begin : g_flag
        // R8
        sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
            err_flags[i] && !(wr_en && !wr_data[i]) |=> err_flags[i]);
        // R8
        clear_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(err_flags[i]) |-> $past(wr_en && !wr_data[i]));
        // R6
        raise_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(err_flags[i]) |-> $past(frame_done || timeout));
    end

endmodule

bind audio_clk_ratio_det acd_chk u_acd_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .status    (status),
    .err_flags (err_flags),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .frame_done(frame_done),
    .timeout   (timeout)
);

// File: tb/tb_audio_clk_ratio_det.sv
module tb_audio_clk_ratio_det;

    localparam int REF = 24_576_000;
    localparam int TMO = REF / 4000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mclk_in = 1'b0, bclk_in = 1'b0, fclk_in = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_data = 3'b111;
    logic [7:0] status;
    logic [2:0] err_flags;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // clock pattern generator (periods in reference cycles)
    int mper = 2, bper = 8, fper = 512, t = 0;
    bit gen_on = 1'b0, f_stop = 1'b0;

    // reference model state
    bit m1, m2, m3, b1, b2, b3, f1, f2, f3;
    int armed, hp, mc, bc, pc, pm, pb, pp, mrate, mratio;
    bit [2:0] merr;

    audio_clk_ratio_det dut (
        .clk(clk), .rst_n(rst_n), .mclk_in(mclk_in), .bclk_in(bclk_in),
        .fclk_in(fclk_in), .wr_en(wr_en), .wr_data(wr_data),
        .status(status), .err_flags(err_flags)
    );

    always #4 clk = ~clk;

    task automatic check(string req, int got, int exp);
        checks++;
        if (got != exp) begin
            fails++;
            if (fails < 30)
                $display("FAIL %s: actual %0d expected %0d at %0t", req, got, exp, $time);
        end
    endtask

    function automatic int cls_ratio(int c);
        int noms[6] = '{64, 128, 192, 256, 384, 512};
        for (int i = 0; i < 6; i++)
            if (c >= noms[i] - 1 && c <= noms[i] + 1) return i;
        return 7;
    endfunction

    function automatic int cls_rate(int p);
        if (p > REF / 6000)   return 7;
        if (p > REF / 12000)  return 0;
        if (p > REF / 19000)  return 1;
        if (p > REF / 28000)  return 2;
        if (p > REF / 38000)  return 3;
        if (p > REF / 66000)  return 4;
        if (p > REF / 130000) return 5;
        return 7;
    endfunction

    function automatic int absd(int a, int b);
        return (a > b) ? a - b : b - a;
    endfunction

    // input pattern driving, away from the active edge
    always @(negedge clk) begin
        if (gen_on) begin
            mclk_in = (t % mper) < (mper / 2 > 0 ? mper / 2 : 1);
            bclk_in = (t % bper) < (bper / 2);
            fclk_in = f_stop ? 1'b0 : ((t % fper) < (fper / 2));
            t++;
        end
    end

    // cycle-level behavioural model
    always @(posedge clk) begin
        bit rm, rb, rf;
        bit [2:0] ne, mask;
        int r, rt;
        bit ok;
        if (!rst_n) begin
            {m1, m2, m3, b1, b2, b3, f1, f2, f3} = '0;
            armed = 0; hp = 0; mc = 0; bc = 0; pc = 0; pm = 0; pb = 0; pp = 0;
            mrate = 7; mratio = 7; merr = '0;
        end else begin
            rm = m2 && !m3; rb = b2 && !b3; rf = f2 && !f3;
            ne = '0;
            mask = wr_en ? wr_data : 3'b111;
            if (rf) begin
                if (armed != 0) begin
                    r  = cls_ratio(mc);
                    rt = cls_rate(pc);
                    ok = (bc == 32) || (bc == 64) || (bc == 48 && (r == 2 || r == 4));
                    if (r == 7) ne[0] = 1'b1;
                    if (!ok) ne[1] = 1'b1;
                    if (rt == 7) ne[2] = 1'b1;
                    if (hp != 0) begin
                        if (absd(mc, pm) > 1) ne[0] = 1'b1;
                        if (bc != pb)         ne[1] = 1'b1;
                        if (absd(pc, pp) > 2) ne[2] = 1'b1;
                    end
                    pm = mc; pb = bc; pp = pc; hp = 1;
                    mratio = r; mrate = rt;
                end
                armed = 1; mc = int'(rm); bc = int'(rb); pc = 1;
            end else if (armed != 0) begin
                if (pc == TMO) begin
                    armed = 0; hp = 0; mrate = 7; mratio = 7; ne[2] = 1'b1;
                end else begin
                    if (rm && mc < 2047) mc++;
                    if (rb && bc < 127)  bc++;
                    pc++;
                end
            end
            merr = (merr & mask) | ne;
            m3 = m2; m2 = m1; m1 = mclk_in;
            b3 = b2; b2 = b1; b1 = bclk_in;
            f3 = f2; f2 = f1; f1 = fclk_in;
        end
    end

    // every-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R4 rate code vs model", int'(status[7:5]), mrate);
            check("R3 ratio code vs model", int'(status[4:2]), mratio);
            check("R6 master flag vs model", int'(err_flags[0]), int'(merr[0]));
            check("R5 bit flag vs model", int'(err_flags[1]), int'(merr[1]));
            check("R7 frame flag vs model", int'(err_flags[2]), int'(merr[2]));
        end
    end

    task automatic cycles(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cfg(int m, int b, int f, bit restart);
        @(negedge clk);
        mper = m; bper = b; fper = f;
        if (restart) t = 0;
    endtask

    task automatic clear(logic [2:0] keep);
        @(negedge clk);
        wr_en = 1'b1; wr_data = keep;
        @(negedge clk);
        wr_en = 1'b0; wr_data = 3'b111;
    endtask

    task automatic settle_clear(int frames);
        cycles(frames * fper);
        clear(3'b000);
        cycles(2 * fper + 10);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        cycles(5);
        // R1 reset state
        check("R1 status after reset", int'(status), 8'hFC);
        check("R1 flags after reset", int'(err_flags), 0);
        rst_n = 1'b1;
        cycles(20);
        check("R2 no frame yet", int'(status), 8'hFC);

        // 256x master, 64x bit clock, 48 kHz frame
        cfg(2, 8, 512, 1'b1);
        gen_on = 1'b1;
        cycles(300);
        check("R2 armed only, codes unchanged", int'(status), 8'hFC);
        cycles(4 * 512);
        check("R3 R4 256x at 48k", int'(status), 8'h8C);
        check("R6 steady stream no flag", int'(err_flags), 0);

        // bit clock changes to 32x mid-stream
        cfg(2, 16, 512, 1'b0);
        cycles(3 * 512);
        check("R6 bit count change flagged", int'(err_flags[1]), 1);
        settle_clear(1);
        check("R5 32x legal", int'(err_flags), 0);
        check("R3 still 256x", int'(status), 8'h8C);

        // 192x master, 48x bit clock, 32 kHz
        cfg(4, 16, 768, 1'b1);
        settle_clear(4);
        check("R5 48x legal with 192x", int'(err_flags), 0);
        check("R3 R4 192x at 32k", int'(status), 8'h68);

        // 256x master with 48x bit clock is illegal
        cfg(3, 16, 768, 1'b1);
        settle_clear(4);
        check("R5 48x illegal with 256x", int'(err_flags), 3'b010);
        check("R3 256x at 32k", int'(status), 8'h6C);

        // leave illegal mode; clear only the bit flag, keep the others
        cfg(2, 8, 512, 1'b1);
        cycles(4 * 512);
        check("R6 frame length change flagged", int'(err_flags[2]), 1);
        clear(3'b101);
        cycles(2 * 512);
        check("R8 written zero clears bit flag", int'(err_flags[1]), 0);
        check("R8 written one keeps frame flag", int'(err_flags[2]), 1);
        clear(3'b000);
        cycles(2 * 512);
        check("R8 all cleared on steady stream", int'(err_flags), 0);

        // 128x bit clock is never legal
        cfg(2, 4, 512, 1'b1);
        settle_clear(3);
        check("R5 128x bit clock persists after clear", int'(err_flags), 3'b010);

        // unsupported master ratio (300x)
        cfg(2, 10, 600, 1'b1);
        settle_clear(3);
        check("R7 unknown ratio code", int'(status), 8'h9C);
        check("R7 master flag persists", int'(err_flags), 3'b011);

        // master ratio halves mid-stream
        cfg(2, 8, 512, 1'b1);
        settle_clear(3);
        check("R6 baseline clean", int'(err_flags), 0);
        cfg(4, 8, 512, 1'b0);
        cycles(3 * 512);
        check("R6 master count change flagged", int'(err_flags), 3'b001);
        check("R3 128x detected", int'(status), 8'h84);

        // stopped frame clock
        cfg(2, 8, 512, 1'b1);
        settle_clear(3);
        f_stop = 1'b1;
        cycles(TMO + 300);
        check("R9 timeout codes none", int'(status), 8'hFC);
        check("R9 timeout frame flag", int'(err_flags[2]), 1);
        @(negedge clk);
        f_stop = 1'b0; t = 0;
        settle_clear(3);
        check("R9 re-armed codes", int'(status), 8'h8C);
        check("R9 re-armed flags clean", int'(err_flags), 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule